// File: doc/BRIEF.md
# Reorder Buffer with Deferred Fault Raising

This block keeps in-flight instructions of an out-of-order core in program order. Dispatch claims a slot at the tail through a valid/ready handshake and gets back the slot index, which serves as the instruction's tag. Execution units later write a result and a fault code into that slot by tag. Retirement reads from the head, up to two slots per cycle, and hands the destination register and value to the architectural register file.

A fault found during execution is stored in the slot like any other result and stays hidden. It becomes visible only when its slot is the oldest one still live. At that point the block raises an exception with the fault code and a handler address, and it discards the faulting slot and every slot behind it. A branch mispredict cuts the buffer back to just after the branch slot in one cycle. Any fault recorded in a discarded slot is therefore never raised.

Back-pressure exists only on dispatch. `alloc_ready` is low when every slot is held, and also in any cycle that carries a mispredict flush or an exception. A transfer happens on a cycle where `alloc_valid` and `alloc_ready` are both high. Writeback is never stalled, and the register file accepts every commit lane the cycle it is offered, so neither of those interfaces has a ready signal. `flush_tag` must name a live slot.

Top module: `rob_core`

## Requirements
- R1: An accepted allocation receives the tag equal to the current tail index, and tags advance by one modulo DEPTH in dispatch order. `alloc_ready` is low whenever DEPTH slots are held.
- R2: Nothing is committed while the head slot has not been written back, even when younger slots are already complete.
- R3: Commits leave strictly in dispatch order with the destination register and value of their slot. Lane 0 carries the older slot. Two slots leave in one cycle when both are complete and fault-free, and lane 1 is never valid without lane 0.
- R4: A writeback with a non-zero fault code (zero means no fault) does not assert `exc_valid` while that slot is not the head.
- R5: Every complete, fault-free slot older than a faulted slot commits before the exception is raised. A faulted slot is never committed on either lane, and no lane is valid while `exc_valid` is high.
- R6: While the head slot is complete and faulted, `exc_valid` is high with `exc_code` equal to the stored code and `exc_redirect` = HANDLER_BASE + code·2^VEC_SHIFT. On the next cycle the buffer is empty, and the next allocation reuses the faulting slot's tag.
- R7: A flush with `flush_tag` = b discards every slot younger than b in one cycle. The next tag offered is b+1 modulo DEPTH, and a fault stored in a discarded slot is never raised.
- R8: `alloc_ready` is low in any cycle where `flush_valid` or `exc_valid` is high.
- R9: After reset the buffer is empty: `alloc_ready` = 1, `alloc_tag` = 0, no commit lane valid, `exc_valid` = 0.
- R10: In a flush cycle, the branch slot itself may still commit on lane 0. A younger complete slot that would otherwise follow it on lane 1 is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch offers an instruction |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_areg | input | AREG_W | Destination architectural register |
| alloc_tag | output | TAG_W | Tag given to the offered instruction |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | TAG_W | Slot being written back |
| wb_data | input | DATA_W | Result value |
| wb_fault | input | FC_W | Fault code, zero for none |
| flush_valid | input | 1 | Branch mispredict flush |
| flush_tag | input | TAG_W | Tag of the mispredicted branch |
| cm_valid | output | 2 | Commit lane valids, bit 0 oldest |
| cm_areg0 | output | AREG_W | Lane 0 destination register |
| cm_data0 | output | DATA_W | Lane 0 value |
| cm_areg1 | output | AREG_W | Lane 1 destination register |
| cm_data1 | output | DATA_W | Lane 1 value |
| exc_valid | output | 1 | Exception raised this cycle |
| exc_code | output | FC_W | Fault code of the raising slot |
| exc_redirect | output | ADDR_W | Handler fetch address |

## Verification
The collision of interest is a mispredict flush arriving in the same cycle as a two-wide commit whose older slot is the branch itself. The bench sets this up by completing the slot after the branch first and the branch last, then driving the flush in the first cycle both are retirable. It judges the result by requiring exactly lane 0 in that cycle, a scoreboard that holds only the branch's value, and a next tag of branch plus one. A second overlap, a fault waiting behind older unfinished slots, is judged by the scoreboard seeing the older commits strictly before the exception entry.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    RT_HOLD  = 2'd0,
    RT_ONE   = 2'd1,
    RT_TWO   = 2'd2,
    RT_RAISE = 2'd3
  } retire_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter  int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PW    = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic [1:0]       commit_n,
  input  logic             squash_all,
  input  logic             flush_valid,
  input  logic [TAG_W-1:0] flush_tag,
  output logic [TAG_W-1:0] head_idx,
  output logic [TAG_W-1:0] tail_idx,
  output logic [PW-1:0]    occ
);

  logic [PW-1:0] head_q, tail_q, keep_n;

  // slots kept by a flush: head up to and including the branch
  assign keep_n   = {1'b0, flush_tag - head_q[TAG_W-1:0]} + PW'(1);
  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign occ      = tail_q - head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + PW'(commit_n);
      if (squash_all)
        tail_q <= head_q;
      else if (flush_valid)
        tail_q <= head_q + keep_n;
      else if (alloc_fire)
        tail_q <= tail_q + PW'(1);
    end
  end

endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter  int DEPTH  = 8,
  parameter  int AREG_W = 5,
  parameter  int DATA_W = 32,
  parameter  int FC_W   = 4,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  tail_idx,
  input  logic [AREG_W-1:0] alloc_areg,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [FC_W-1:0]   wb_fault,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              h0_done,
  output logic [FC_W-1:0]   h0_fault,
  output logic [AREG_W-1:0] h0_areg,
  output logic [DATA_W-1:0] h0_data,
  output logic              h1_done,
  output logic [FC_W-1:0]   h1_fault,
  output logic [AREG_W-1:0] h1_areg,
  output logic [DATA_W-1:0] h1_data
);

  logic [DEPTH-1:0] done_v;
  logic [FC_W-1:0]   fault_a [DEPTH];
  logic [AREG_W-1:0] areg_a  [DEPTH];
  logic [DATA_W-1:0] data_a  [DEPTH];
  logic [TAG_W-1:0]  next_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              done_q;
    logic [FC_W-1:0]   fault_q;
    logic [AREG_W-1:0] areg_q;
    logic [DATA_W-1:0] data_q;
    logic              hit_alloc, hit_wb;

    assign hit_alloc = alloc_fire && (tail_idx == TAG_W'(g));
    assign hit_wb    = wb_valid && (wb_tag == TAG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q  <= 1'b0;
        fault_q <= '0;
      end else if (hit_alloc) begin
        done_q  <= 1'b0;
        fault_q <= '0;
      end else if (hit_wb) begin
        done_q  <= 1'b1;
        fault_q <= wb_fault;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) areg_q <= alloc_areg;
      if (hit_wb && !hit_alloc) data_q <= wb_data;
    end

    assign done_v[g]  = done_q;
    assign fault_a[g] = fault_q;
    assign areg_a[g]  = areg_q;
    assign data_a[g]  = data_q;
  end

  assign next_idx = head_idx + TAG_W'(1);

  assign h0_done  = done_v[head_idx];
  assign h0_fault = fault_a[head_idx];
  assign h0_areg  = areg_a[head_idx];
  assign h0_data  = data_a[head_idx];
  assign h1_done  = done_v[next_idx];
  assign h1_fault = fault_a[next_idx];
  assign h1_areg  = areg_a[next_idx];
  assign h1_data  = data_a[next_idx];

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter  int DEPTH = 8,
  parameter  int FC_W  = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PW    = TAG_W + 1
) (
  input  logic [PW-1:0]    occ,
  input  logic [TAG_W-1:0] head_idx,
  input  logic             h0_done,
  input  logic [FC_W-1:0]  h0_fault,
  input  logic             h1_done,
  input  logic [FC_W-1:0]  h1_fault,
  input  logic             flush_valid,
  input  logic [TAG_W-1:0] flush_tag,
  output logic [1:0]       cm_valid,
  output logic [1:0]       commit_n,
  output logic             raise
);
  import rob_pkg::*;

  retire_e decision;
  logic    live0, live1, clean0, clean1, cut_after_head;

  assign live0          = (occ != '0);
  assign live1          = (occ > PW'(1));
  assign clean0         = h0_done && (h0_fault == '0);
  assign clean1         = h1_done && (h1_fault == '0);
  assign cut_after_head = flush_valid && (flush_tag == head_idx);

  always_comb begin
    decision = RT_HOLD;
    if (live0 && h0_done) begin
      if (!clean0)
        decision = RT_RAISE;
      else if (live1 && clean1 && !cut_after_head)
        decision = RT_TWO;
      else
        decision = RT_ONE;
    end
  end

  always_comb begin
    unique case (decision)
      RT_ONE:   begin cm_valid = 2'b01; commit_n = 2'd1; raise = 1'b0; end
      RT_TWO:   begin cm_valid = 2'b11; commit_n = 2'd2; raise = 1'b0; end
      RT_RAISE: begin cm_valid = 2'b00; commit_n = 2'd0; raise = 1'b1; end
      default:  begin cm_valid = 2'b00; commit_n = 2'd0; raise = 1'b0; end
    endcase
  end

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter  int          DEPTH        = 8,
  parameter  int          AREG_W       = 5,
  parameter  int          DATA_W       = 32,
  parameter  int          FC_W         = 4,
  parameter  int          ADDR_W       = 32,
  parameter  int          VEC_SHIFT    = 4,
  parameter  logic [31:0] HANDLER_BASE = 32'h0000_8000,
  localparam int          TAG_W        = $clog2(DEPTH),
  localparam int          PW           = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [AREG_W-1:0] alloc_areg,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [FC_W-1:0]   wb_fault,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  output logic [1:0]        cm_valid,
  output logic [AREG_W-1:0] cm_areg0,
  output logic [DATA_W-1:0] cm_data0,
  output logic [AREG_W-1:0] cm_areg1,
  output logic [DATA_W-1:0] cm_data1,
  output logic              exc_valid,
  output logic [FC_W-1:0]   exc_code,
  output logic [ADDR_W-1:0] exc_redirect
);

  logic [TAG_W-1:0] head_idx, tail_idx;
  logic [PW-1:0]    occ;
  logic [1:0]       commit_n;
  logic             raise, alloc_fire;
  logic             h0_done, h1_done;
  logic [FC_W-1:0]  h0_fault, h1_fault;

  assign alloc_ready = (occ != PW'(DEPTH)) && !flush_valid && !raise;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_idx;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .commit_n(commit_n),
    .squash_all(raise), .flush_valid(flush_valid), .flush_tag(flush_tag),
    .head_idx(head_idx), .tail_idx(tail_idx), .occ(occ)
  );

  rob_slots #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .FC_W(FC_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .tail_idx(tail_idx),
    .alloc_areg(alloc_areg), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_data(wb_data), .wb_fault(wb_fault), .head_idx(head_idx),
    .h0_done(h0_done), .h0_fault(h0_fault), .h0_areg(cm_areg0), .h0_data(cm_data0),
    .h1_done(h1_done), .h1_fault(h1_fault), .h1_areg(cm_areg1), .h1_data(cm_data1)
  );

  rob_retire #(.DEPTH(DEPTH), .FC_W(FC_W)) u_retire (
    .occ(occ), .head_idx(head_idx), .h0_done(h0_done), .h0_fault(h0_fault),
    .h1_done(h1_done), .h1_fault(h1_fault), .flush_valid(flush_valid),
    .flush_tag(flush_tag), .cm_valid(cm_valid), .commit_n(commit_n), .raise(raise)
  );

  assign exc_valid    = raise;
  assign exc_code     = h0_fault;
  assign exc_redirect = ADDR_W'(HANDLER_BASE) + (ADDR_W'(h0_fault) << VEC_SHIFT);

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter  int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PW    = TAG_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             flush_valid,
  input logic [TAG_W-1:0] flush_tag,
  input logic [1:0]       cm_valid,
  input logic             exc_valid,
  input logic [PW-1:0]    occ
);

  assert_full_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == PW'(DEPTH)) |-> !alloc_ready);

  assert_lane_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid[1] |-> cm_valid[0]);

  assert_no_commit_on_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (cm_valid == 2'b00));

  assert_raise_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (occ == '0));

  assert_flush_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !exc_valid) |=> (alloc_tag == TAG_W'($past(flush_tag) + 1'b1)));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid || exc_valid) |-> !alloc_ready);

endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .flush_valid(flush_valid), .flush_tag(flush_tag), .cm_valid(cm_valid),
  .exc_valid(exc_valid), .occ(occ)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;
  localparam int          DEPTH = 8;
  localparam int          TW    = 3;
  localparam logic [31:0] HB    = 32'h0000_8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, wb_valid = 0, flush_valid = 0;
  logic [4:0]  alloc_areg = '0;
  logic [TW-1:0] wb_tag = '0, flush_tag = '0;
  logic [31:0] wb_data = '0;
  logic [3:0]  wb_fault = '0;
  logic        alloc_ready, exc_valid;
  logic [TW-1:0] alloc_tag;
  logic [1:0]  cm_valid;
  logic [4:0]  cm_areg0, cm_areg1;
  logic [31:0] cm_data0, cm_data1, exc_redirect;
  logic [3:0]  exc_code;

  int n_cmp = 0, n_bad = 0, dual_seen = 0;
  logic [36:0] exp_q[$];
  logic [35:0] exc_q[$];

  always #5 clk = ~clk;

  rob_core u_rob_core (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_areg(alloc_areg), .alloc_tag(alloc_tag), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_data), .wb_fault(wb_fault),
    .flush_valid(flush_valid), .flush_tag(flush_tag), .cm_valid(cm_valid),
    .cm_areg0(cm_areg0), .cm_data0(cm_data0), .cm_areg1(cm_areg1),
    .cm_data1(cm_data1), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_redirect(exc_redirect)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic lane(input logic [4:0] a, input logic [31:0] d);
    logic [36:0] e;
    if (exp_q.size() == 0) chk(1'b0, "R3 unexpected commit", {a, d}, 0);
    else begin
      e = exp_q.pop_front();
      chk({a, d} == e, "R3 commit order/value", {a, d}, e);
    end
  endtask

  // monitor: outputs sampled mid-cycle, inputs change just after posedge
  always @(negedge clk) if (rst_n) begin
    if (cm_valid[0]) lane(cm_areg0, cm_data0);
    if (cm_valid[1]) begin lane(cm_areg1, cm_data1); dual_seen++; end
    if (exc_valid) begin
      if (exc_q.size() == 0) chk(1'b0, "R7 unexpected exception", exc_code, 0);
      else begin
        logic [35:0] e;
        e = exc_q.pop_front();
        chk({exc_code, exc_redirect} == e, "R6 exception code/redirect",
            {exc_code, exc_redirect}, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [4:0] a, input logic [TW-1:0] exp_tag);
    alloc_valid = 1; alloc_areg = a;
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
    chk(alloc_tag == exp_tag, "R1 tag", alloc_tag, exp_tag);
    @(posedge clk); #1;
    alloc_valid = 0;
  endtask

  task automatic do_wb(input logic [TW-1:0] t, input logic [31:0] d, input logic [3:0] f);
    wb_valid = 1; wb_tag = t; wb_data = d; wb_fault = f;
    @(posedge clk); #1;
    wb_valid = 0;
  endtask

  task automatic peek_tag(input logic [TW-1:0] exp_tag, input string req);
    @(negedge clk);
    chk(alloc_tag == exp_tag, req, alloc_tag, exp_tag);
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(alloc_ready == 1'b1, "R9 ready after reset", alloc_ready, 1);
    chk(alloc_tag == 0, "R9 tag after reset", alloc_tag, 0);
    chk(cm_valid == 0, "R9 no commit", cm_valid, 0);
    chk(exc_valid == 0, "R9 no exception", exc_valid, 0);
    @(posedge clk); #1;

    // T1: out-of-order completion, in-order commit (R2, R3)
    do_alloc(5'd1, 0); exp_q.push_back({5'd1, 32'h11});
    do_alloc(5'd2, 1); exp_q.push_back({5'd2, 32'h22});
    do_alloc(5'd3, 2); exp_q.push_back({5'd3, 32'h33});
    do_wb(2, 32'h33, 0);
    @(negedge clk); chk(cm_valid == 0, "R2 head pending", cm_valid, 0);
    @(posedge clk); #1;
    do_wb(1, 32'h22, 0);
    @(negedge clk); chk(cm_valid == 0, "R2 head pending", cm_valid, 0);
    @(posedge clk); #1;
    do_wb(0, 32'h11, 0);
    idle(4);
    chk(exp_q.size() == 0, "R3 drain T1", exp_q.size(), 0);

    // T2: fill to capacity (R1), reverse completion
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(5'(i + 8), TW'(i + 3));
      exp_q.push_back({5'(i + 8), 32'(100 + i)});
    end
    @(negedge clk); chk(alloc_ready == 1'b0, "R1 full blocks", alloc_ready, 0);
    @(posedge clk); #1;
    for (int i = DEPTH - 1; i >= 0; i--) do_wb(TW'(i + 3), 32'(100 + i), 0);
    idle(6);
    chk(exp_q.size() == 0, "R3 drain T2", exp_q.size(), 0);
    chk(dual_seen > 0, "R3 two-wide commit seen", dual_seen, 1);

    // T3: deferred fault behind older slots (R4, R5, R6)
    do_alloc(5'd20, 3); exp_q.push_back({5'd20, 32'hA0});
    do_alloc(5'd21, 4); exp_q.push_back({5'd21, 32'hB0});
    do_alloc(5'd22, 5);
    do_alloc(5'd23, 6);
    do_wb(5, 32'hC0, 4'd5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk(exc_valid == 0, "R4 fault hidden", exc_valid, 0);
      @(posedge clk); #1;
    end
    do_wb(6, 32'hD0, 0);
    exc_q.push_back({4'd5, HB + 32'h50});
    do_wb(3, 32'hA0, 0);
    do_wb(4, 32'hB0, 0);
    idle(4);
    chk(exp_q.size() == 0 && exc_q.size() == 0, "R5 older commits then raise",
        exp_q.size() + exc_q.size(), 0);
    peek_tag(5, "R6 tag reuse after raise");

    // T4: fault on squashed path (R7, R8)
    do_alloc(5'd24, 5);
    do_alloc(5'd25, 6);
    do_alloc(5'd26, 7);
    do_wb(6, 32'hE0, 4'd7);
    idle(2);
    flush_valid = 1; flush_tag = 5;
    @(negedge clk); chk(alloc_ready == 1'b0, "R8 busy during flush", alloc_ready, 0);
    @(posedge clk); #1;
    flush_valid = 0;
    peek_tag(6, "R7 tail after flush");
    exp_q.push_back({5'd24, 32'hF0});
    do_wb(5, 32'hF0, 0);
    do_alloc(5'd27, 6); exp_q.push_back({5'd27, 32'h1F});
    do_wb(6, 32'h1F, 0);
    idle(4);
    chk(exp_q.size() == 0 && exc_q.size() == 0, "R7 squashed fault silent",
        exp_q.size(), 0);

    // T5: flush in the same cycle as a two-wide commit (R10)
    do_alloc(5'd28, 7); exp_q.push_back({5'd28, 32'h77});
    do_alloc(5'd29, 0);
    do_alloc(5'd30, 1);
    do_wb(0, 32'h88, 0);
    do_wb(1, 32'h99, 0);
    do_wb(7, 32'h77, 0);
    flush_valid = 1; flush_tag = 7;
    @(negedge clk); chk(cm_valid == 2'b01, "R10 branch only commits", cm_valid, 1);
    @(posedge clk); #1;
    flush_valid = 0;
    peek_tag(0, "R7 tail after flush with commit");
    idle(4);
    chk(exp_q.size() == 0 && exc_q.size() == 0, "R10 nothing after branch",
        exp_q.size(), 0);

    finish_run();
  end
endmodule